// File: doc/BRIEF.md
# Shared Timer Clock-Enable Prescaler

This block generates count-enable pulses for three timer/counters from one shared 10-bit prescaler counter. The counter runs on the system clock. Each timer has its own 3-bit source select. The select can stop the timer, pass the system clock through undivided, pick one of four divided taps, or use a synchronized edge of that timer's external input pin. Each output is a one-cycle enable pulse in the system clock domain. The timers are assumed to advance on cycles where their enable is high.

A small control register lets software halt all timers together and restart them together. It has a shared prescaler reset bit and a hold (synchronization) bit. While the hold bit is set, a written reset bit stays asserted. Clearing the hold bit makes the hardware drop both reset bits in the same cycle. Every timer that uses the same source then receives its first enable on the same cycle. A second reset bit is stored and read back but drives nothing here. External pins are sampled and edge-detected, never used as clocks.

There is no data stream in this block, so no valid/ready handshake is needed. All pins are plain control and status pins. A register write is accepted in every cycle where `ctl_wr_en` is high.

Top module: `tpsc_top`

## Requirements
- R1: After reset the prescaler counter is 0. While the shared reset bit is clear, the counter increments by one each cycle and wraps modulo 1024.
- R2: Select code 0 gives no enable pulse for that timer.
- R3: Select code 1 gives an enable on every cycle in which the shared reset bit reads 0.
- R4: Select codes 2, 3, 4 and 5 each give one enable per 8, 64, 256 and 1024 cycles respectively. The pulse appears in the cycle where the low 3, 6, 8 or 10 counter bits are all ones. After a release, the counter restarts from 0, so the first pulse comes 7, 63, 255 or 1023 cycles after the release.
- R5: Select code 6 gives a pulse on a falling pin edge and code 7 on a rising pin edge. The pin passes through a 2-flop synchronizer and an edge flop. A pin change set up before clock edge n shows as a pulse in the cycle after edge n+1. The pin is never divided. Each pin phase must last at least two system cycles.
- R6: A write with bit 7 = 0 and bit 0 = 1 makes bit 0 read 1 for exactly one cycle. In that cycle no enable is given, and the counter then restarts from 0.
- R7: While bit 7 reads 1, a written reset bit (bit 0 or bit 1) stays set until a later write clears bit 7. While bit 0 reads 1, all three enables are 0, for every select code.
- R8: A write with bit 7 = 0 and reset bits 0 clears bits 0 and 1 on the same edge. All timers that use the same select code then get their first enable on the same cycle.
- R9: Register layout: bit 7 = hold (synchronization) bit, bit 1 = second reset bit (stored only), bit 0 = shared reset bit. Bits 6..2 read 0. The reset value is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control register write value |
| ctl_rd_data | output | 8 | Control register read value |
| tmr_sel | input | 9 | Per-timer 3-bit source select; timer i in bits [3i+2:3i] |
| ext_pin | input | 3 | Per-timer external count pin, asynchronous |
| cnt_en | output | 3 | Per-timer one-cycle count-enable pulse |

## Verification
The hardest case to reach from the ports is the joint release. Three timers must be held with the prescaler frozen for many cycles, the second reset bit set while held, and then all of them released by one write. The first enables must then be shown to line up on a divided tap, not only on the undivided source. A directed sequence builds this state step by step and counts the cycles from the release edge for each timer. Constrained-random phases then mix all select codes, toggling pins with legal phase lengths, and random control writes. These writes land the hold and reset bits in every combination, while a bench model predicts every enable and every read value.

// File: rtl/tpsc_pkg.sv
package tpsc_pkg;
  parameter int CNT_W    = 10;
  parameter int SEL_W    = 3;
  parameter int NUM_TAPS = 4;
  parameter int REG_W    = 8;

  localparam int CTL_HOLD_BIT = 7;
  localparam int CTL_RST2_BIT = 1;
  localparam int CTL_RST_BIT  = 0;

  typedef enum logic [SEL_W-1:0] {
    SRC_OFF      = 3'd0,
    SRC_DIV1     = 3'd1,
    SRC_TAP0     = 3'd2,
    SRC_TAP1     = 3'd3,
    SRC_TAP2     = 3'd4,
    SRC_TAP3     = 3'd5,
    SRC_PIN_FALL = 3'd6,
    SRC_PIN_RISE = 3'd7
  } src_sel_e;

  // log2 of the division ratio of tap i; the top tap always uses the full counter
  function automatic int tap_log2(input int i);
    case (i)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return CNT_W;
    endcase
  endfunction
endpackage

// File: rtl/tpsc_ctl_reg.sv
module tpsc_ctl_reg
  import tpsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             clr_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic hold_q, rst_q, rst2_q;
  logic unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[REG_W-2:CTL_RST2_BIT+1]};

  // A written reset bit survives the next edge only while hold is set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      rst_q  <= 1'b0;
      rst2_q <= 1'b0;
    end else if (wr_en) begin
      hold_q <= wr_data[CTL_HOLD_BIT];
      rst_q  <= wr_data[CTL_RST_BIT]  | (rst_q  & wr_data[CTL_HOLD_BIT]);
      rst2_q <= wr_data[CTL_RST2_BIT] | (rst2_q & wr_data[CTL_HOLD_BIT]);
    end else begin
      rst_q  <= rst_q  & hold_q;
      rst2_q <= rst2_q & hold_q;
    end
  end

  assign clr_o = rst_q;

  always_comb begin
    rd_data_o               = '0;
    rd_data_o[CTL_HOLD_BIT] = hold_q;
    rd_data_o[CTL_RST2_BIT] = rst2_q;
    rd_data_o[CTL_RST_BIT]  = rst_q;
  end
endmodule

// File: rtl/tpsc_divider.sv
module tpsc_divider
  import tpsc_pkg::*;
#(
  parameter int W = CNT_W,
  parameter int T = NUM_TAPS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  output logic [T-1:0] tap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < T; i++) begin : g_tap
    localparam int LW = (tap_log2(i) > W) ? W : tap_log2(i);
    assign tap_o[i] = &cnt_q[LW-1:0];
  end
endmodule

// File: rtl/tpsc_pin_edge.sv
module tpsc_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~last_q;
  assign fall_o = ~sync_q & last_q;
endmodule

// File: rtl/tpsc_src_mux.sv
module tpsc_src_mux
  import tpsc_pkg::*;
(
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                run_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                en_o
);
  logic src;

  always_comb begin
    case (src_sel_e'(sel_i))
      SRC_DIV1:     src = 1'b1;
      SRC_TAP0:     src = tap_i[0];
      SRC_TAP1:     src = tap_i[1];
      SRC_TAP2:     src = tap_i[2];
      SRC_TAP3:     src = tap_i[3];
      SRC_PIN_FALL: src = fall_i;
      SRC_PIN_RISE: src = rise_i;
      default:      src = 1'b0;
    endcase
  end

  assign en_o = src & run_i;
endmodule

// File: rtl/tpsc_top.sv
module tpsc_top
  import tpsc_pkg::*;
#(
  parameter int NUM_TMR = 3,
  parameter int PSC_W   = CNT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctl_wr_en,
  input  logic [REG_W-1:0]         ctl_wr_data,
  output logic [REG_W-1:0]         ctl_rd_data,
  input  logic [NUM_TMR*SEL_W-1:0] tmr_sel,
  input  logic [NUM_TMR-1:0]       ext_pin,
  output logic [NUM_TMR-1:0]       cnt_en
);
  logic                clr;
  logic [NUM_TAPS-1:0] taps;

  tpsc_ctl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctl_wr_en),
    .wr_data   (ctl_wr_data),
    .clr_o     (clr),
    .rd_data_o (ctl_rd_data)
  );

  tpsc_divider #(.W(PSC_W), .T(NUM_TAPS)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr),
    .tap_o (taps)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    logic rise, fall;

    tpsc_pin_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (ext_pin[t]),
      .rise_o (rise),
      .fall_o (fall)
    );

    tpsc_src_mux u_mux (
      .sel_i  (tmr_sel[t*SEL_W +: SEL_W]),
      .run_i  (~clr),
      .tap_i  (taps),
      .rise_i (rise),
      .fall_i (fall),
      .en_o   (cnt_en[t])
    );
  end
endmodule

// File: rtl/tpsc_chk.sv
module tpsc_chk
  import tpsc_pkg::*;
#(
  parameter int NUM_TMR = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ctl_wr_en,
  input logic [REG_W-1:0]         ctl_wr_data,
  input logic [REG_W-1:0]         ctl_rd_data,
  input logic [NUM_TMR*SEL_W-1:0] tmr_sel,
  input logic [NUM_TMR-1:0]       cnt_en
);
  // R9: unused register bits always read zero
  a_r9_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd_data[CTL_HOLD_BIT-1:CTL_RST2_BIT+1] == '0);

  // R6: without hold, the shared reset bit lasts a single cycle
  a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd_data[CTL_RST_BIT] && !ctl_rd_data[CTL_HOLD_BIT] && !ctl_wr_en)
      |=> !ctl_rd_data[CTL_RST_BIT]);

  // R7: with hold, the shared reset bit persists
  a_r7_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd_data[CTL_RST_BIT] && ctl_rd_data[CTL_HOLD_BIT] && !ctl_wr_en)
      |=> ctl_rd_data[CTL_RST_BIT]);

  // R7: no enable at all while the prescaler reset is asserted
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd_data[CTL_RST_BIT] |-> (cnt_en == '0));

  // R8: releasing hold clears both reset bits together
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && !ctl_wr_data[CTL_HOLD_BIT] &&
     !ctl_wr_data[CTL_RST_BIT] && !ctl_wr_data[CTL_RST2_BIT])
      |=> (ctl_rd_data[CTL_RST_BIT] == 1'b0 && ctl_rd_data[CTL_RST2_BIT] == 1'b0));

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_t
    // R2: stopped timer never enabled
    a_r2_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_sel[t*SEL_W +: SEL_W] == 3'd0) |-> !cnt_en[t]);
    // R3: undivided source runs every cycle outside reset
    a_r3_undivided: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_sel[t*SEL_W +: SEL_W] == 3'd1 && !ctl_rd_data[CTL_RST_BIT]) |-> cnt_en[t]);
    // R4: divide-by-8 tap never pulses two cycles in a row
    a_r4_tap_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_sel[t*SEL_W +: SEL_W] == 3'd2 && cnt_en[t]
       && $stable(tmr_sel[t*SEL_W +: SEL_W])) |=> !cnt_en[t]);
  end
endmodule

bind tpsc_top tpsc_chk #(.NUM_TMR(NUM_TMR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_wr_en   (ctl_wr_en),
  .ctl_wr_data (ctl_wr_data),
  .ctl_rd_data (ctl_rd_data),
  .tmr_sel     (tmr_sel),
  .cnt_en      (cnt_en)
);

// File: tb/tpsc_top_tb.sv
module tpsc_top_tb;
  localparam int NT = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [7:0]    wr_data;
  logic [7:0]    rd;
  logic [NT*3-1:0] sel;
  logic [NT-1:0] pin;
  logic [NT-1:0] en;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tpsc_top u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(wr_en), .ctl_wr_data(wr_data),
    .ctl_rd_data(rd), .tmr_sel(sel), .ext_pin(pin), .cnt_en(en)
  );

  // Reference state built from the requirements
  logic          m_hold, m_rst, m_rst2;
  logic [9:0]    m_cnt;
  logic [NT-1:0] m_s1, m_s2, m_s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold <= 0; m_rst <= 0; m_rst2 <= 0; m_cnt <= 0;
      m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
    end else begin
      if (wr_en) begin
        m_hold <= wr_data[7];
        m_rst  <= wr_data[0] | (m_rst  & wr_data[7]);
        m_rst2 <= wr_data[1] | (m_rst2 & wr_data[7]);
      end else begin
        m_rst  <= m_rst  & m_hold;
        m_rst2 <= m_rst2 & m_hold;
      end
      m_cnt <= m_rst ? 10'd0 : m_cnt + 10'd1;
      m_s1 <= pin; m_s2 <= m_s1; m_s3 <= m_s2;
    end
  end

  function automatic logic exp_en(input logic [2:0] s, input int ch);
    if (m_rst) return 1'b0;
    case (s)
      3'd1: return 1'b1;
      3'd2: return m_cnt[2:0] == 3'h7;
      3'd3: return m_cnt[5:0] == 6'h3f;
      3'd4: return m_cnt[7:0] == 8'hff;
      3'd5: return m_cnt == 10'h3ff;
      3'd6: return !m_s2[ch] && m_s3[ch];
      3'd7: return m_s2[ch] && !m_s3[ch];
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] s);
    if (m_rst)   return "R7";
    if (s == 0)  return "R2";
    if (s == 1)  return "R3";
    if (s <= 5)  return "R4";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    for (int ch = 0; ch < NT; ch++) begin
      logic e;
      e = exp_en(sel[ch*3 +: 3], ch);
      check(en[ch] == e, tag_of(sel[ch*3 +: 3]), en[ch], e);
    end
    check(rd == {m_hold, 5'b0, m_rst2, m_rst}, "R9", rd, {m_hold, 5'b0, m_rst2, m_rst});
  endtask

  int hp_left[NT];
  bit pins_on = 1'b0;

  task automatic step();
    @(negedge clk);
    cmp_all();
    wr_en = 1'b0;
    if (pins_on) begin
      for (int ch = 0; ch < NT; ch++) begin
        if (hp_left[ch] <= 1) begin
          pin[ch] = ~pin[ch];
          hp_left[ch] = 2 + int'($urandom_range(4));
        end else hp_left[ch]--;
      end
    end
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int first[NT];
    logic [7:0] wv[6] = '{8'h00, 8'h01, 8'h80, 8'h81, 8'h82, 8'h03};
    void'($urandom(32'd1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; sel = '0; pin = '0;
    for (int ch = 0; ch < NT; ch++) hp_left[ch] = 3;
    repeat (3) @(negedge clk);
    check(rd == 8'h00, "R9", rd, 0);           // R9 reset value
    check(en == '0, "R1", en, 0);              // R1 quiet in reset
    rst_n = 1'b1;

    // R3 / R6: undivided then a single-cycle prescaler reset
    sel = {3'd1, 3'd1, 3'd1};
    step(); step();
    check(en == 3'b111, "R3", en, 7);
    wr(8'h01);
    step();
    check(rd[0] == 1'b1 && en == 0, "R6", {rd[0], en}, 8);
    step();
    check(rd[0] == 1'b0 && en == 3'b111, "R6", {rd[0], en}, 7);

    // R1 / R4: restart from zero, divide-by-8 first pulse 7 cycles on
    sel = {3'd2, 3'd2, 3'd2};
    wr(8'h01); step();
    for (int k = 0; k < 9; k++) begin
      step();
      check(en == ((k == 7) ? 3'b111 : 3'b000), "R4", en, (k == 7) ? 7 : 0);
    end

    // R7 / R8: hold, set second reset, release together on the /64 tap
    sel = {3'd3, 3'd3, 3'd3};
    wr(8'h81); step();
    for (int k = 0; k < 20; k++) step();
    check(en == 0 && rd == 8'h81, "R7", rd, 8'h81);
    wr(8'h82); step();
    check(rd == 8'h83, "R7", rd, 8'h83);
    wr(8'h00);
    for (int ch = 0; ch < NT; ch++) first[ch] = -1;
    for (int k = 0; k < 70; k++) begin
      step();
      if (k == 0) check(rd == 8'h00, "R8", rd, 0);
      for (int ch = 0; ch < NT; ch++)
        if (en[ch] && first[ch] < 0) first[ch] = k;
    end
    for (int ch = 0; ch < NT; ch++) check(first[ch] == 63, "R8", first[ch], 63);

    // R5 directed: rising edge latency
    sel = {3'd6, 3'd7, 3'd7};
    pin = '0; step(); step(); step();
    pin = 3'b111; step();                       // edge n sampled
    check(en == 0, "R5", en, 0);
    step();
    check(en == 3'b011, "R5", en, 3);
    step();
    check(en == 0, "R5", en, 0);

    // Constrained random phases
    pins_on = 1'b1;
    for (int ph = 0; ph < 36; ph++) begin
      int len;
      for (int ch = 0; ch < NT; ch++) sel[ch*3 +: 3] = 3'($urandom_range(7));
      len = 300 + int'($urandom_range(2400));
      for (int c = 0; c < len; c++) begin
        step();
        if ($urandom_range(199) == 0) wr(wv[$urandom_range(5)]);
      end
    end
    wr(8'h00); step(); step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule